// File: doc/BRIEF.md
# 100BASE-TX Receive Carrier and Error Control

This block sits between a 100 Mb/s symbol decoder and a media-independent interface. On the receive side it takes one decoded symbol per clock, tagged by kind (data nibble, idle, J, K, T, R or invalid). A receive state machine with four states turns this stream into carrier sense, receive data valid, receive error and the receive nibble. Carrier starts on a J/K start-of-stream pair and ends on a T/R end-of-stream pair. If the frame ends on idle without that pair, carrier is dropped and a single-cycle receive error marks the early end. An invalid symbol inside a frame is replaced on the nibble bus by a fixed error code.

A separate transmit state machine with four states turns the MAC's enable, error and nibble inputs into symbol requests. It opens each frame with J then K and closes it with T then R. Any cycle where the MAC flags a transmit error becomes an H symbol. Both paths have registered outputs, one clock after their inputs.

Receive states: REST (no carrier), SAW_J (J seen, waiting for K), FRAME (carrier on), SAW_T (T seen, waiting for R). Receive transitions:
- REST to SAW_J on J.
- SAW_J to FRAME on K.
- SAW_J to REST on any other kind, which is a false carrier.
- FRAME to SAW_T on T.
- FRAME to REST on idle, which is an early end.
- SAW_T to REST on R, or on any other kind with an error.

Transmit states: TIDLE, TK, TDATA, TEND. Transmit transitions:
- TIDLE to TK when enable rises.
- TK to TDATA while enable stays high.
- TK or TDATA to TEND when enable falls.
- TEND to TIDLE always.

Top module: `mii100_carrier_ctrl`

## Requirements
- R1: Symbol kinds are coded on 3 bits as 0 data, 1 idle, 2 J, 3 K, 4 T, 5 R, 6 and 7 invalid. A J followed at once by K makes the outputs one clock after the K show crs=1, rx_dv=1, rx_er=0, rxd=0101.
- R2: Inside a frame, T followed at once by R ends the frame. The output for the T has crs=1 and rx_dv=0, and the output for the R has crs=0 and rx_dv=0, all with rx_er=0.
- R3: Inside a frame, an idle symbol (or any symbol other than R after T) drops crs and rx_dv and raises rx_er with rxd=0000 for exactly one clock. The next output has rx_er=0.
- R4: Inside a frame, an invalid symbol or a stray J, K or R gives rx_er=1 and rxd=1110, with crs and rx_dv held high.
- R5: Inside a frame, a data symbol gives rxd equal to its nibble, rx_dv=1, crs=1, rx_er=0.
- R6: A J not followed at once by K is a false carrier. The next output has rx_er=1, rxd=1110, rx_dv=0, crs=0, and the block returns to no carrier.
- R7: Outside a frame, symbols other than J leave all receive outputs low and rxd=0000.
- R8: Transmit kinds use the R1 coding. On the first cycle of tx_en the next tx_kind is J, on the second it is K, and later cycles give data with tx_nib equal to txd.
- R9: A cycle with tx_en and tx_er both high gives tx_kind H (6) on the next clock.
- R10: After tx_en falls the transmit side gives T, then R, then idle (1). tx_nib is 0 for every non-data kind.
- R11: During reset every receive output is 0 and tx_kind is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_kind | input | 3 | Kind of the received symbol |
| rx_nib | input | 4 | Nibble carried by a received data symbol |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rxd | output | 4 | Receive nibble |
| tx_en | input | 1 | MAC transmit enable |
| tx_er | input | 1 | MAC transmit error |
| txd | input | 4 | MAC transmit nibble |
| tx_kind | output | 3 | Kind of symbol requested for the line |
| tx_nib | output | 4 | Nibble of a requested data symbol |

## Verification
A receive error substitution and a transmit H insertion can fall in the same cycle, because the two state machines share only the clock. The bench provokes this by placing an invalid receive symbol inside an open frame in the same clock that the MAC holds both enable and error high. It then judges both registered outputs after that one edge: the receive side must show 1110 with error while carrier and valid stay up, and the transmit side must request H. Neither result may disturb the next symbol on either path.

// File: rtl/mii100_pkg.sv
package mii100_pkg;
    localparam int KIND_W = 3;
    localparam int NIB_W  = 4;

    typedef enum logic [KIND_W-1:0] {
        SYM_DATA = 3'd0,
        SYM_IDLE = 3'd1,
        SYM_J    = 3'd2,
        SYM_K    = 3'd3,
        SYM_T    = 3'd4,
        SYM_R    = 3'd5,
        SYM_H    = 3'd6
    } sym_kind_t;
endpackage

// File: rtl/mii100_rx_fsm.sv
module mii100_rx_fsm
    import mii100_pkg::*;
#(
    parameter int            W       = NIB_W,
    parameter logic [W-1:0]  PRE_NIB = 4'b0101,
    parameter logic [W-1:0]  ERR_NIB = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [W-1:0]      nib_i,
    output logic              crs_o,
    output logic              dv_o,
    output logic              er_o,
    output logic [W-1:0]      rxd_o
);
    typedef enum logic [1:0] {RX_REST, RX_SAW_J, RX_FRAME, RX_SAW_T} rx_state_t;

    rx_state_t st, nxt;
    sym_kind_t k;
    logic          n_crs, n_dv, n_er;
    logic [W-1:0]  n_rxd;

    assign k = sym_kind_t'(kind_i);

    always_comb begin
        nxt   = st;
        n_crs = 1'b0;
        n_dv  = 1'b0;
        n_er  = 1'b0;
        n_rxd = '0;
        unique case (st)
            RX_REST: begin
                if (k == SYM_J) nxt = RX_SAW_J;
            end
            RX_SAW_J: begin
                if (k == SYM_K) begin
                    nxt   = RX_FRAME;
                    n_crs = 1'b1;
                    n_dv  = 1'b1;
                    n_rxd = PRE_NIB;
                end else begin
                    nxt   = RX_REST;
                    n_er  = 1'b1;
                    n_rxd = ERR_NIB;
                end
            end
            RX_FRAME: begin
                case (k)
                    SYM_DATA: begin
                        n_crs = 1'b1;
                        n_dv  = 1'b1;
                        n_rxd = nib_i;
                    end
                    SYM_IDLE: begin
                        nxt  = RX_REST;
                        n_er = 1'b1;
                    end
                    SYM_T: begin
                        nxt   = RX_SAW_T;
                        n_crs = 1'b1;
                    end
                    default: begin
                        n_crs = 1'b1;
                        n_dv  = 1'b1;
                        n_er  = 1'b1;
                        n_rxd = ERR_NIB;
                    end
                endcase
            end
            RX_SAW_T: begin
                nxt = RX_REST;
                if (k != SYM_R) n_er = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_REST;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crs_o <= 1'b0;
            dv_o  <= 1'b0;
            er_o  <= 1'b0;
            rxd_o <= '0;
        end else begin
            crs_o <= n_crs;
            dv_o  <= n_dv;
            er_o  <= n_er;
            rxd_o <= n_rxd;
        end
    end
endmodule

// File: rtl/mii100_tx_fsm.sv
module mii100_tx_fsm
    import mii100_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              er_i,
    input  logic [W-1:0]      d_i,
    output logic [KIND_W-1:0] kind_o,
    output logic [W-1:0]      nib_o
);
    typedef enum logic [1:0] {TX_IDLE, TX_K, TX_DATA, TX_END} tx_state_t;

    tx_state_t  st, nxt;
    sym_kind_t  n_kind;
    logic [W-1:0] n_nib;

    always_comb begin
        nxt    = st;
        n_kind = SYM_IDLE;
        n_nib  = '0;
        unique case (st)
            TX_IDLE: begin
                if (en_i) begin
                    nxt    = TX_K;
                    n_kind = SYM_J;
                end
            end
            TX_K: begin
                if (en_i) begin
                    nxt    = TX_DATA;
                    n_kind = SYM_K;
                end else begin
                    nxt    = TX_END;
                    n_kind = SYM_T;
                end
            end
            TX_DATA: begin
                if (en_i) begin
                    n_kind = SYM_DATA;
                    n_nib  = d_i;
                end else begin
                    nxt    = TX_END;
                    n_kind = SYM_T;
                end
            end
            TX_END: begin
                nxt    = TX_IDLE;
                n_kind = SYM_R;
            end
        endcase
        if (en_i && er_i) begin
            n_kind = SYM_H;
            n_nib  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o <= SYM_IDLE;
            nib_o  <= '0;
        end else begin
            kind_o <= n_kind;
            nib_o  <= n_nib;
        end
    end
endmodule

// File: rtl/mii100_carrier_ctrl.sv
module mii100_carrier_ctrl
    import mii100_pkg::*;
#(
    parameter logic [NIB_W-1:0] PRE_NIB = 4'b0101,
    parameter logic [NIB_W-1:0] ERR_NIB = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] rx_kind,
    input  logic [NIB_W-1:0]  rx_nib,
    output logic              crs,
    output logic              rx_dv,
    output logic              rx_er,
    output logic [NIB_W-1:0]  rxd,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [NIB_W-1:0]  txd,
    output logic [KIND_W-1:0] tx_kind,
    output logic [NIB_W-1:0]  tx_nib
);
    mii100_rx_fsm #(.W(NIB_W), .PRE_NIB(PRE_NIB), .ERR_NIB(ERR_NIB)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (rx_kind),
        .nib_i  (rx_nib),
        .crs_o  (crs),
        .dv_o   (rx_dv),
        .er_o   (rx_er),
        .rxd_o  (rxd)
    );

    mii100_tx_fsm #(.W(NIB_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tx_en),
        .er_i   (tx_er),
        .d_i    (txd),
        .kind_o (tx_kind),
        .nib_o  (tx_nib)
    );
endmodule

// File: rtl/mii100_carrier_chk.sv
module mii100_carrier_chk
    import mii100_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [KIND_W-1:0] rx_kind,
    input logic              crs,
    input logic              rx_dv,
    input logic              rx_er,
    input logic [NIB_W-1:0]  rxd,
    input logic              tx_en,
    input logic              tx_er,
    input logic [KIND_W-1:0] tx_kind
);
    assert_crs_on_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs) |-> ($past(rx_kind) == SYM_K));

    assert_crs_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crs) |-> (($past(rx_kind) == SYM_R) || rx_er));

    assert_early_end_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(crs) && rx_er) |=> !rx_er);

    assert_err_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_er && rx_dv) |-> (rxd == 4'b1110));

    assert_dv_needs_crs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs);

    assert_tx_h_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_er) |=> (tx_kind == SYM_H));
endmodule

bind mii100_carrier_ctrl mii100_carrier_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_kind (rx_kind),
    .crs     (crs),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .rxd     (rxd),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .tx_kind (tx_kind)
);

// File: tb/sim_mii100_carrier_ctrl.sv
module sim_mii100_carrier_ctrl;
    localparam logic [2:0] KD = 3'd0, KI = 3'd1, KJ = 3'd2, KK = 3'd3,
                           KT = 3'd4, KR = 3'd5, KH = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rx_kind = KI;
    logic [3:0] rx_nib = '0;
    logic       tx_en = 1'b0, tx_er = 1'b0;
    logic [3:0] txd = '0;
    logic       crs, rx_dv, rx_er;
    logic [3:0] rxd;
    logic [2:0] tx_kind;
    logic [3:0] tx_nib;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mii100_carrier_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_kind(rx_kind), .rx_nib(rx_nib),
        .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .tx_kind(tx_kind), .tx_nib(tx_nib)
    );

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] rk, input logic [3:0] rn,
                        input logic te, input logic tr, input logic [3:0] td);
        @(negedge clk);
        rx_kind = rk; rx_nib = rn; tx_en = te; tx_er = tr; txd = td;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [6:0] rxo();
        return {crs, rx_dv, rx_er, rxd};
    endfunction

    task automatic rx_step(input logic [2:0] rk, input logic [3:0] rn);
        step(rk, rn, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 rx outputs", rxo(), 7'b0);
        chk("R11 tx kind", {4'b0, tx_kind}, {4'b0, KI});
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_frame;
        rx_step(KI, 4'h0);  chk("R7 idle", rxo(), 7'b0);
        rx_step(KD, 4'h7);  chk("R7 data outside frame", rxo(), 7'b0);
        rx_step(KJ, 4'h0);  chk("R1 J alone", rxo(), 7'b0);
        rx_step(KK, 4'h0);  chk("R1 JK preamble", rxo(), {3'b110, 4'b0101});
        rx_step(KD, 4'hA);  chk("R5 data A", rxo(), {3'b110, 4'hA});
        rx_step(KD, 4'h3);  chk("R5 data 3", rxo(), {3'b110, 4'h3});
        rx_step(KT, 4'h0);  chk("R2 T", rxo(), {3'b100, 4'h0});
        rx_step(KR, 4'h0);  chk("R2 R", rxo(), 7'b0);
        rx_step(KD, 4'h9);  chk("R7 after frame", rxo(), 7'b0);
    endtask

    task automatic t_err;
        rx_step(KJ, 4'h0);
        rx_step(KK, 4'h0);
        rx_step(KH, 4'h0);  chk("R4 invalid", rxo(), {3'b111, 4'b1110});
        rx_step(KD, 4'h5);  chk("R4 recover", rxo(), {3'b110, 4'h5});
        rx_step(KR, 4'h0);  chk("R4 stray R", rxo(), {3'b111, 4'b1110});
        rx_step(3'd7, 4'h0); chk("R4 code 7", rxo(), {3'b111, 4'b1110});
        rx_step(KT, 4'h0);
        rx_step(KR, 4'h0);  chk("R2 close", rxo(), 7'b0);
    endtask

    task automatic t_early;
        rx_step(KJ, 4'h0);
        rx_step(KK, 4'h0);
        rx_step(KD, 4'h1);
        rx_step(KI, 4'h0);  chk("R3 idle end", rxo(), {3'b001, 4'h0});
        rx_step(KI, 4'h0);  chk("R3 one cycle", rxo(), 7'b0);
        rx_step(KJ, 4'h0);
        rx_step(KK, 4'h0);
        rx_step(KT, 4'h0);
        rx_step(KI, 4'h0);  chk("R3 T without R", rxo(), {3'b001, 4'h0});
        rx_step(KD, 4'h2);  chk("R3 after T end", rxo(), 7'b0);
    endtask

    task automatic t_false;
        rx_step(KJ, 4'h0);
        rx_step(KD, 4'h4);  chk("R6 J then data", rxo(), {3'b001, 4'b1110});
        rx_step(KI, 4'h0);  chk("R6 back to rest", rxo(), 7'b0);
        rx_step(KJ, 4'h0);
        rx_step(KJ, 4'h0);  chk("R6 J then J", rxo(), {3'b001, 4'b1110});
        rx_step(KK, 4'h0);  chk("R6 K after false", rxo(), 7'b0);
    endtask

    task automatic t_tx;
        step(KI, 0, 1'b1, 1'b0, 4'h5); chk("R8 J", {tx_nib, tx_kind}, {4'h0, KJ});
        step(KI, 0, 1'b1, 1'b0, 4'h5); chk("R8 K", {tx_nib, tx_kind}, {4'h0, KK});
        step(KI, 0, 1'b1, 1'b0, 4'h9); chk("R8 data", {tx_nib, tx_kind}, {4'h9, KD});
        step(KI, 0, 1'b1, 1'b1, 4'h2); chk("R9 H", {tx_nib, tx_kind}, {4'h0, KH});
        step(KI, 0, 1'b1, 1'b0, 4'hC); chk("R8 data after H", {tx_nib, tx_kind}, {4'hC, KD});
        step(KI, 0, 1'b0, 1'b0, 4'hF); chk("R10 T", {tx_nib, tx_kind}, {4'h0, KT});
        step(KI, 0, 1'b0, 1'b0, 4'h0); chk("R10 R", {tx_nib, tx_kind}, {4'h0, KR});
        step(KI, 0, 1'b0, 1'b0, 4'h0); chk("R10 idle", {tx_nib, tx_kind}, {4'h0, KI});
    endtask

    task automatic t_both;
        step(KJ, 0, 1'b1, 1'b0, 4'h5);
        step(KK, 0, 1'b1, 1'b0, 4'h5);
        step(KD, 4'h6, 1'b1, 1'b0, 4'h8);
        step(KH, 0, 1'b1, 1'b1, 4'h8);
        chk("R4 rx in shared cycle", rxo(), {3'b111, 4'b1110});
        chk("R9 tx in shared cycle", {tx_nib, tx_kind}, {4'h0, KH});
        step(KD, 4'hB, 1'b1, 1'b0, 4'h1);
        chk("R5 rx after shared", rxo(), {3'b110, 4'hB});
        chk("R8 tx after shared", {tx_nib, tx_kind}, {4'h1, KD});
        step(KT, 0, 1'b0, 1'b0, 4'h0);
        step(KR, 0, 1'b0, 1'b0, 4'h0);
        chk("R2 rx closed", rxo(), 7'b0);
        chk("R10 tx R", {tx_nib, tx_kind}, {4'h0, KR});
    endtask

    initial begin
        t_reset;
        t_frame;
        t_err;
        t_early;
        t_false;
        t_tx;
        t_both;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule